// File: doc/BRIEF.md
# Dual-Mode Tick Timer

A register-programmed timer peripheral that runs either as a 32-bit down-counter or as a seconds counter with a 32-bit compare value. Software programs it through a simple synchronous register port. It writes a configuration code, a mode bit, a control word, a reload value, a compare value and an interrupt mask. It reads back these settings, the live counter, the raw event status and the masked status. The reload and compare values are each kept as two 16-bit halves.

In countdown mode the counter decrements on every cycle in which the `cnt_tick` enable is high. When it is stepped while at zero, a timeout event occurs. The counter then either reloads (periodic) or stops (one-shot), and it can emit a one-cycle pulse toward an ADC. In seconds mode the counter increments on each `sec_tick` pulse, and a compare hit raises its own status bit. Status bits are cleared by writing ones to a clear register. A level interrupt is raised whenever a status bit and its mask bit are both set. Configuration codes other than the two supported modes are accepted into the register, but the counter does not run under them.

Top module: `gp_dual_timer`

## Requirements
- R1: After synchronous reset, every register, the counter, `irq`, `adc_trig` and `bus_rdata` are zero.
- R2: Register map (word address on `bus_addr`): 0 config (bits 2:0), 1 mode (bit 0 = one-shot), 2 control (bit 0 = run, bit 5 = ADC trigger enable), 3 mask, 4 raw status, 5 masked status, 6 clear, 7 reload, 8 compare, 9 counter. A write to address 7 or 8 stores bits 15:0 and 31:16 as the two halves. A read returns the full 32-bit value when config is below 4, and only bits 15:0 otherwise.
- R3: A control write that sets bit 0 while the timer is stopped loads the counter. Under config 0 the counter takes the reload value, and under config 1 it becomes 0.
- R4: Under config 0, while running, each `cnt_tick` cycle decrements the counter. A tick while the counter is 0 is a timeout, which sets status bit 0. In periodic mode (mode bit 0 = 0) a timeout reloads the counter.
- R5: In one-shot mode a timeout clears control bit 0 and leaves the counter at 0.
- R6: Under config 1, while running, each `sec_tick` cycle increments the counter. When the incremented value equals the compare value, status bit 1 is set. `cnt_tick` has no effect in this mode.
- R7: `adc_trig` is high for the cycle after a timeout exactly when control bit 5 was set. A compare hit in seconds mode never pulses it.
- R8: A mask write keeps only bits 0x77 of the written value. Reading address 5 returns status AND mask. `irq` is high exactly when that value is nonzero, and it changes on the same clock edge as the status.
- R9: Writing 1s to address 6 clears those status bits. An event in the same cycle takes precedence over the clear of its bit.
- R10: Under config codes 2 to 7 the counter never changes and no timeout or compare event occurs.
- R11: While control bit 0 is clear, the counter holds its value.
- R12: A read request is answered on `bus_rdata` one cycle later. `bus_rdata` holds its value until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cnt_tick | input | 1 | Countdown step enable |
| sec_tick | input | 1 | Once-per-second step enable |
| irq | output | 1 | Masked interrupt level |
| adc_trig | output | 1 | One-cycle ADC trigger pulse |

## Verification
The hardest case to reach is a status event that lands in the same cycle as a software clear of that same bit. The bench reaches it with a reload value of 0 in periodic mode and `cnt_tick` held high, so that a timeout fires on every cycle. It then issues clear writes against that stream. It also drives a one-shot timeout and a seconds-mode compare hit with the trigger enable still set, which shows that only the countdown timeout reaches `adc_trig`. A long pseudo-random phase mixes writes to every address, including unsupported config codes, with random tick patterns. A behavioural model checks this phase on every clock.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 4;
  localparam int CFG_W  = 3;

  localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MIS   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd6;
  localparam logic [ADDR_W-1:0] A_LOAD  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MATCH = 4'd8;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd9;

  localparam logic [CFG_W-1:0] CFG_DOWN  = 3'd0;
  localparam logic [CFG_W-1:0] CFG_RTC   = 3'd1;
  localparam logic [CFG_W-1:0] CFG_SPLIT = 3'd4;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_TRIG = 5;
  localparam int ST_TO     = 0;
  localparam int ST_HIT    = 1;
endpackage

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              oneshot,
  input  logic              run_en,
  input  logic              en_rise,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] match_val,
  input  logic              cnt_tick,
  input  logic              sec_tick,
  output logic [DATA_W-1:0] count,
  output logic              timeout,
  output logic              match_hit,
  output logic              oneshot_stop
);
  logic is_down, is_rtc, down_step, rtc_step;
  logic [DATA_W-1:0] incr;

  assign is_down      = (cfg == CFG_DOWN);
  assign is_rtc       = (cfg == CFG_RTC);
  assign down_step    = run_en && is_down && cnt_tick;
  assign rtc_step     = run_en && is_rtc && sec_tick;
  assign incr         = count + 1'b1;
  assign timeout      = down_step && (count == '0);
  assign match_hit    = rtc_step && (incr == match_val);
  assign oneshot_stop = timeout && oneshot;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (en_rise && is_down) begin
      count <= load_val;
    end else if (en_rise && is_rtc) begin
      count <= '0;
    end else if (timeout) begin
      if (!oneshot) count <= load_val;
    end else if (down_step) begin
      count <= count - 1'b1;
    end else if (rtc_step) begin
      count <= incr;
    end
  end

  // R11
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !en_rise) |=> $stable(count));
  // R10
  unsupported_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg > CFG_RTC) |-> (!timeout && !match_hit));
  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    oneshot_stop |=> (count == '0));
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq
  import gpt_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] MASK_KEEP = 8'h77
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timeout,
  input  logic              match_hit,
  input  logic              trig_en,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic              mask_wr,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq,
  output logic              adc_trig
);
  logic [STAT_W-1:0] status_d, mask_d;

  always_comb begin
    status_d = status & ~clr_vec;
    if (timeout)   status_d[ST_TO]  = 1'b1;
    if (match_hit) status_d[ST_HIT] = 1'b1;
    mask_d = mask_wr ? (mask_wdata & MASK_KEEP) : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      mask     <= '0;
      irq      <= 1'b0;
      adc_trig <= 1'b0;
    end else begin
      status   <= status_d;
      mask     <= mask_d;
      irq      <= |(status_d & mask_d);
      adc_trig <= timeout && trig_en;
    end
  end

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_vec[ST_TO] && !timeout) |=> !status[ST_TO]);
  // R7
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout && trig_en) |=> adc_trig);
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((status & mask) != '0));
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int STAT_W = 8,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              oneshot_stop,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [DATA_W-1:0] count,
  output logic [CFG_W-1:0]  cfg,
  output logic              oneshot,
  output logic              run_en,
  output logic              trig_en,
  output logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] match_val,
  output logic              en_rise,
  output logic [STAT_W-1:0] clr_vec,
  output logic              mask_wr
);
  logic wr, rd, full_view;
  logic [HALF_W-1:0] load_lo, load_hi, match_lo, match_hi;
  logic [DATA_W-1:0] rd_mux;

  assign wr        = bus_sel && bus_wr;
  assign rd        = bus_sel && !bus_wr;
  assign load_val  = {load_hi, load_lo};
  assign match_val = {match_hi, match_lo};
  assign full_view = (cfg < CFG_SPLIT);
  assign en_rise   = wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_RUN] && !run_en;
  assign clr_vec   = (wr && bus_addr == A_CLR) ? bus_wdata[STAT_W-1:0] : '0;
  assign mask_wr   = wr && (bus_addr == A_MASK);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CFG:   rd_mux[CFG_W-1:0] = cfg;
      A_MODE:  rd_mux[0] = oneshot;
      A_CTRL:  begin
        rd_mux[CTRL_RUN]  = run_en;
        rd_mux[CTRL_TRIG] = trig_en;
      end
      A_MASK:  rd_mux[STAT_W-1:0] = mask;
      A_RAW:   rd_mux[STAT_W-1:0] = status;
      A_MIS:   rd_mux[STAT_W-1:0] = status & mask;
      A_LOAD:  rd_mux = full_view ? load_val : {{HALF_W{1'b0}}, load_lo};
      A_MATCH: rd_mux = full_view ? match_val : {{HALF_W{1'b0}}, match_lo};
      A_COUNT: rd_mux = count;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      oneshot   <= 1'b0;
      run_en    <= 1'b0;
      trig_en   <= 1'b0;
      load_lo   <= '0;
      load_hi   <= '0;
      match_lo  <= '0;
      match_hi  <= '0;
      bus_rdata <= '0;
    end else begin
      if (oneshot_stop) run_en <= 1'b0;
      if (wr) begin
        case (bus_addr)
          A_CFG:  cfg <= bus_wdata[CFG_W-1:0];
          A_MODE: oneshot <= bus_wdata[0];
          A_CTRL: begin
            run_en  <= bus_wdata[CTRL_RUN];
            trig_en <= bus_wdata[CTRL_TRIG];
          end
          A_LOAD: begin
            load_lo <= bus_wdata[HALF_W-1:0];
            load_hi <= bus_wdata[DATA_W-1:HALF_W];
          end
          A_MATCH: begin
            match_lo <= bus_wdata[HALF_W-1:0];
            match_hi <= bus_wdata[DATA_W-1:HALF_W];
          end
          default: ;
        endcase
      end
      if (rd) bus_rdata <= rd_mux;
    end
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gp_dual_timer.sv
module gp_dual_timer
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int STAT_W = 8,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_tick,
  input  logic              sec_tick,
  output logic              irq,
  output logic              adc_trig
);
  logic [CFG_W-1:0]  cfg;
  logic              oneshot, run_en, trig_en, en_rise, mask_wr;
  logic              timeout, match_hit, oneshot_stop;
  logic [DATA_W-1:0] load_val, match_val, count;
  logic [STAT_W-1:0] status, mask, clr_vec;

  gpt_regs #(.HALF_W(HALF_W), .STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .oneshot_stop(oneshot_stop), .status(status), .mask(mask), .count(count),
    .cfg(cfg), .oneshot(oneshot), .run_en(run_en), .trig_en(trig_en),
    .load_val(load_val), .match_val(match_val), .en_rise(en_rise),
    .clr_vec(clr_vec), .mask_wr(mask_wr)
  );

  gpt_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst(rst), .cfg(cfg), .oneshot(oneshot), .run_en(run_en),
    .en_rise(en_rise), .load_val(load_val), .match_val(match_val),
    .cnt_tick(cnt_tick), .sec_tick(sec_tick), .count(count),
    .timeout(timeout), .match_hit(match_hit), .oneshot_stop(oneshot_stop)
  );

  gpt_irq #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .timeout(timeout), .match_hit(match_hit),
    .trig_en(trig_en), .clr_vec(clr_vec), .mask_wr(mask_wr),
    .mask_wdata(bus_wdata[STAT_W-1:0]), .status(status), .mask(mask),
    .irq(irq), .adc_trig(adc_trig)
  );

  // R5
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (oneshot_stop && !(bus_sel && bus_wr && bus_addr == A_CTRL)) |=> !run_en);
endmodule

// File: tb/sim_gp_dual_timer.sv
module sim_gp_dual_timer;
  localparam int HALF_W = 16;
  localparam int DATA_W = 32;
  localparam int STAT_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic cnt_tick = 1'b0, sec_tick = 1'b0;
  logic irq, adc_trig;

  always #4 clk = ~clk;

  gp_dual_timer #(.HALF_W(HALF_W), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .sec_tick(sec_tick), .irq(irq), .adc_trig(adc_trig)
  );

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit armed = 1'b0;

  // behavioural reference state
  logic [2:0]  m_cfg;
  logic        m_os, m_en, m_te, m_irq, m_trig;
  logic [7:0]  m_mask, m_st, m_clr;
  logic [31:0] m_load, m_match, m_cnt, m_rd, m_ncnt;
  logic        m_nen, m_to, m_hit, m_rise, m_wr;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {29'd0, m_cfg};
      4'd1: return {31'd0, m_os};
      4'd2: return {26'd0, m_te, 4'd0, m_en};
      4'd3: return {24'd0, m_mask};
      4'd4: return {24'd0, m_st};
      4'd5: return {24'd0, m_st & m_mask};
      4'd7: return (m_cfg < 4) ? m_load : (m_load & 32'hFFFF);
      4'd8: return (m_cfg < 4) ? m_match : (m_match & 32'hFFFF);
      4'd9: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = 0; m_os = 0; m_en = 0; m_te = 0; m_irq = 0; m_trig = 0;
      m_mask = 0; m_st = 0; m_load = 0; m_match = 0; m_cnt = 0; m_rd = 0;
    end else begin
      if (bus_sel && !bus_wr) m_rd = m_read(bus_addr);
      m_wr = bus_sel && bus_wr;
      m_rise = m_wr && bus_addr == 4'd2 && bus_wdata[0] && !m_en;
      m_to = 0; m_hit = 0; m_ncnt = m_cnt; m_nen = m_en;
      if (m_rise) begin
        if (m_cfg == 0) m_ncnt = m_load;
        else if (m_cfg == 1) m_ncnt = 0;
      end else if (m_en && m_cfg == 0 && cnt_tick) begin
        if (m_cnt == 0) begin
          m_to = 1;
          if (m_os) m_nen = 0; else m_ncnt = m_load;
        end else m_ncnt = m_cnt - 1;
      end else if (m_en && m_cfg == 1 && sec_tick) begin
        m_ncnt = m_cnt + 1;
        m_hit = (m_ncnt == m_match);
      end
      m_clr = (m_wr && bus_addr == 4'd6) ? bus_wdata[7:0] : 8'd0;
      m_st = m_st & ~m_clr;
      if (m_to) m_st[0] = 1'b1;
      if (m_hit) m_st[1] = 1'b1;
      m_trig = m_to && m_te;
      m_cnt = m_ncnt;
      m_en = m_nen;
      if (m_wr) begin
        case (bus_addr)
          4'd0: m_cfg = bus_wdata[2:0];
          4'd1: m_os = bus_wdata[0];
          4'd2: begin m_en = bus_wdata[0]; m_te = bus_wdata[5]; end
          4'd3: m_mask = bus_wdata[7:0] & 8'h77;
          4'd7: m_load = bus_wdata;
          4'd8: m_match = bus_wdata;
          default: ;
        endcase
      end
      m_irq = |(m_st & m_mask);
    end
  end

  task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("irq", {31'd0, irq}, {31'd0, m_irq});
      chk("adc_trig", {31'd0, adc_trig}, {31'd0, m_trig});
      chk("bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n, input logic ct, input logic st);
    cnt_tick = ct; sec_tick = st;
    for (int i = 0; i < n; i++) @(negedge clk);
    cnt_tick = 0; sec_tick = 0;
  endtask

  // explicit expectation on a read, in addition to the model
  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp);
    rd_reg(a);
    chk("direct read", bus_rdata, exp);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    armed = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    // R1: reset values read back as zero
    cur_req = "R1";
    for (int a = 0; a < 10; a++) rd_expect(a[3:0], 32'd0);

    // R2: split halves and narrow view
    cur_req = "R2";
    wr_reg(4'd7, 32'h1234_5678);
    rd_expect(4'd7, 32'h1234_5678);
    wr_reg(4'd8, 32'hCAFE_0042);
    rd_expect(4'd8, 32'hCAFE_0042);
    wr_reg(4'd0, 32'd4);
    rd_expect(4'd7, 32'h0000_5678);
    rd_expect(4'd8, 32'h0000_0042);
    wr_reg(4'd0, 32'd0);

    // R8: mask keeps 0x77
    cur_req = "R8";
    wr_reg(4'd3, 32'hFFFF_FFFF);
    rd_expect(4'd3, 32'h77);

    // R3: enable edge loads reload value
    cur_req = "R3";
    wr_reg(4'd7, 32'd3);
    wr_reg(4'd2, 32'h21);
    rd_expect(4'd9, 32'd3);

    // R4 / R7: periodic countdown with trigger pulses
    cur_req = "R4";
    idle(2, 1, 0);
    rd_expect(4'd9, 32'd1);
    cur_req = "R7";
    idle(9, 1, 0);
    rd_expect(4'd4, 32'h1);

    // R9: clear, then clear racing a timeout every cycle
    cur_req = "R9";
    wr_reg(4'd6, 32'h1);
    rd_expect(4'd4, 32'h0);
    wr_reg(4'd2, 32'h0);
    wr_reg(4'd7, 32'd0);
    wr_reg(4'd2, 32'h1);
    cnt_tick = 1;
    wr_reg(4'd6, 32'h1);
    rd_reg(4'd4);
    cnt_tick = 0;
    chk("status after racing clear", bus_rdata, 32'h1);

    // R11: stopped counter holds
    cur_req = "R11";
    wr_reg(4'd2, 32'h0);
    wr_reg(4'd6, 32'hFF);
    wr_reg(4'd7, 32'd50);
    wr_reg(4'd2, 32'h1);
    idle(5, 1, 0);
    wr_reg(4'd2, 32'h0);
    idle(6, 1, 0);
    rd_reg(4'd9);

    // R5: one-shot stops at zero
    cur_req = "R5";
    wr_reg(4'd1, 32'h1);
    wr_reg(4'd7, 32'd2);
    wr_reg(4'd2, 32'h21);
    idle(6, 1, 0);
    rd_expect(4'd2, 32'h20);
    rd_expect(4'd9, 32'd0);
    wr_reg(4'd1, 32'h0);

    // R6: seconds mode with compare; R7 no trigger here
    cur_req = "R6";
    wr_reg(4'd6, 32'hFF);
    wr_reg(4'd0, 32'd1);
    wr_reg(4'd8, 32'd3);
    wr_reg(4'd2, 32'h21);
    rd_expect(4'd9, 32'd0);
    idle(4, 1, 0);
    rd_expect(4'd9, 32'd0);
    for (int k = 0; k < 3; k++) begin idle(1, 1, 1); idle(2, 0, 0); end
    rd_expect(4'd4, 32'h2);
    rd_expect(4'd5, 32'h2);
    cur_req = "R8";
    wr_reg(4'd3, 32'h0);
    idle(2, 0, 0);

    // R10: unsupported configurations do not count
    cur_req = "R10";
    wr_reg(4'd2, 32'h0);
    wr_reg(4'd6, 32'hFF);
    wr_reg(4'd0, 32'd2);
    wr_reg(4'd2, 32'h1);
    idle(8, 1, 1);
    rd_expect(4'd4, 32'h0);
    wr_reg(4'd0, 32'd6);
    idle(8, 1, 1);
    rd_reg(4'd9);

    // R12: unmapped reads and data hold
    cur_req = "R12";
    rd_expect(4'd15, 32'd0);
    rd_expect(4'd11, 32'd0);
    idle(3, 0, 0);

    // mixed traffic under the model
    cur_req = "R4";
    wr_reg(4'd3, 32'h77);
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      cnt_tick = lfsr[0] | lfsr[1];
      sec_tick = lfsr[2] & lfsr[3];
      if (lfsr[7:4] < 4'd3) begin
        bus_sel = 1; bus_wr = lfsr[8]; bus_addr = lfsr[12:9] % 4'd10;
        if (bus_addr == 4'd0) bus_wdata = {29'd0, lfsr[14:13] == 2'd3 ? 3'd5 : {2'b00, lfsr[15]}};
        else if (bus_addr == 4'd7 || bus_addr == 4'd8) bus_wdata = {24'd0, lfsr[31:24]};
        else bus_wdata = {lfsr[15:0], lfsr[31:16]};
      end else begin
        bus_sel = 0;
      end
      @(negedge clk);
    end
    bus_sel = 0; cnt_tick = 0; sec_tick = 0;
    idle(3, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule